// File: doc/BRIEF.md
# Cascaded Sync Waveform Counter Generator

This block is a bank of programmable counter generators that together build display timing waveforms: line sync, frame sync, active-line and active-pixel windows. Each generator advances on events from a selectable source. The source can be a pixel-rate tick, nothing, or the period strobe of any generator in the bank. Chaining generators this way turns a pixel counter into a line counter, and a line counter into a frame counter.

Each generator has three phases. It first waits a programmed number of offset events from its own offset source. It then runs periods of `run count + 1` run-source events, emitting a one-cycle strobe at the end of each period. After a programmed number of periods it stops, unless it is set to reload forever. A clear source restarts the offset and repeat sequence. The waveform output is high while the generator's position, counted in half-pixel units, lies between a programmed rising and falling value. A per-generator polarity bit inverts the final output.

All fields are held in a small word-write register file. The bank runs while `run_en` is high. Lowering `run_en` returns every generator to its starting state.

Top module: `sync_wave_bank`

## Requirements
- R1: After a synchronous active-low reset, every configuration field and polarity bit is zero, and `strobe_o` and `wave_o` are all low.
- R2: With run source code 1 (pixel tick) and run count N, a running generator asserts its strobe for one cycle once every N+1 ticks. The strobe is registered and appears the cycle after the tick that completes the period.
- R3: After a start or a clear, a generator counts `off_cnt` events of its offset source, then enters the run phase with position 0. An offset of 0 enters the run phase on the next cycle.
- R4: With a nonzero repeat count K and the reload bit clear, the generator stops after K strobes. From then on its raw waveform is low and it emits no strobe until cleared or restarted.
- R5: A repeat count of 0, or the reload bit set, makes the generator run periods indefinitely.
- R6: An event on the clear source (code not 0) returns the generator to its offset phase with all counters at zero. In that cycle it suppresses any strobe, even one that would end a period in the same cycle.
- R7: The raw waveform is high exactly when the generator is in its run phase and 2 times its position count is at least `up` and below `down`. Values are in half-pixel units.
- R8: Source codes 2 to 7 select the strobe of generator code-2 as it was one cycle earlier. A code naming a generator that is absent never fires.
- R9: `wave_o[i]` is the raw waveform of generator i XOR polarity bit i.
- R10: Source code 0 never fires, so a generator with run source 0 never strobes.
- R11: While `run_en` is low, every generator is held in its starting state: offset phase, counters zero, no strobe.
- R12: A write places generator g's fields at word address g*4+sel. With sel 0: run count [30:19], run source [18:16], offset count [14:3], offset source [2:0]. With sel 1: up [9:0], down [25:16], clear source [28:26], reload [31]. With sel 2: repeat count [15:0]. Address 3 holds the polarity bits [NGEN-1:0]. A write takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Bank enable; low holds all generators at start |
| pix_tick | input | 1 | Pixel-rate event (source code 1) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| wave_o | output | NGEN | Per-generator waveform after polarity |
| strobe_o | output | NGEN | Per-generator period-end strobe |

## Verification
Two things can fall in the same cycle: the clear event and the event that completes a period. When they coincide, the clear must win and the strobe must be lost. A directed case produces this coincidence repeatedly. It clears a period-4 generator from the strobe of a period-5 sibling. After the first coincidence the two stay in lock step, so the cleared generator must strobe exactly once. Random configurations also select sibling strobes as clear, offset and run sources. Every cycle is judged against a bench reference model that applies the clear before the period logic.

// File: rtl/swg_pkg.sv
// Shared widths, field positions and types for the sync waveform bank.
// Assumes at most 6 generators, so that 3-bit source codes can name every one.
package swg_pkg;
    localparam int SRC_W   = 3;
    localparam int NSRC    = 1 << SRC_W;
    localparam int CNT_W   = 12;
    localparam int EDGE_W  = 10;
    localparam int REP_W   = 16;
    localparam int SEL_W   = 2;
    localparam int GIDX_W  = 3;
    localparam int ADDR_W  = GIDX_W + SEL_W;
    localparam int DATA_W  = 32;
    localparam int SRC_GEN_BASE = 2;

    // word 0 field positions
    localparam int W0_RUN_CNT = 19;
    localparam int W0_RUN_SRC = 16;
    localparam int W0_OFF_CNT = 3;
    localparam int W0_OFF_SRC = 0;
    // word 1 field positions
    localparam int W1_UP      = 0;
    localparam int W1_DOWN    = 16;
    localparam int W1_CLR     = 26;
    localparam int W1_RELOAD  = 31;

    localparam logic [ADDR_W-1:0] POL_ADDR = ADDR_W'(3);

    typedef enum logic [1:0] {
        PH_OFFS = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0]  run_cnt;
        logic [SRC_W-1:0]  run_src;
        logic [CNT_W-1:0]  off_cnt;
        logic [SRC_W-1:0]  off_src;
        logic [EDGE_W-1:0] up;
        logic [EDGE_W-1:0] down;
        logic [SRC_W-1:0]  clr_src;
        logic              reload;
        logic [REP_W-1:0]  rep_cnt;
    } gen_cfg_t;
endpackage

// File: rtl/swg_cfg_regs.sv
// Configuration store: per-generator timing fields and the polarity word.
// Assumes one word write per cycle; addresses naming absent generators are dropped.
module swg_cfg_regs
    import swg_pkg::*;
#(
    parameter int NGEN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output gen_cfg_t          cfg_q [NGEN],
    output logic [NGEN-1:0]   pol_q
);
    logic [GIDX_W-1:0] gidx;
    logic [SEL_W-1:0]  sel;

    assign gidx = addr[ADDR_W-1:SEL_W];
    assign sel  = addr[SEL_W-1:0];

    // Capture field writes into the addressed generator's configuration.
    always_ff @(posedge clk) begin
        for (int g = 0; g < NGEN; g++) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (we && gidx == GIDX_W'(g)) begin
                case (sel)
                    2'd0: begin
                        cfg_q[g].run_cnt <= wdata[W0_RUN_CNT +: CNT_W];
                        cfg_q[g].run_src <= wdata[W0_RUN_SRC +: SRC_W];
                        cfg_q[g].off_cnt <= wdata[W0_OFF_CNT +: CNT_W];
                        cfg_q[g].off_src <= wdata[W0_OFF_SRC +: SRC_W];
                    end
                    2'd1: begin
                        cfg_q[g].up      <= wdata[W1_UP +: EDGE_W];
                        cfg_q[g].down    <= wdata[W1_DOWN +: EDGE_W];
                        cfg_q[g].clr_src <= wdata[W1_CLR +: SRC_W];
                        cfg_q[g].reload  <= wdata[W1_RELOAD];
                    end
                    2'd2: cfg_q[g].rep_cnt <= wdata[REP_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Capture the polarity word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_q <= '0;
        else if (we && addr == POL_ADDR)
            pol_q <= wdata[NGEN-1:0];
    end
endmodule

// File: rtl/swg_unit.sv
// One counter generator: offset wait, repeated periods, clear restart and edge window.
// Assumes the event vector is already registered upstream (no combinational loops).
module swg_unit
    import swg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [NSRC-1:0] ev,
    input  gen_cfg_t        cfg,
    output logic            strobe,
    output logic            wave_raw
);
    localparam int POS_W = CNT_W + 1;

    phase_e           phase;
    logic [CNT_W-1:0] ocnt;
    logic [CNT_W-1:0] rcnt;
    logic [REP_W-1:0] reps;
    logic             run_ev, off_ev, clr_ev, forever_run, last_rep;
    logic [POS_W-1:0] pos;

    assign run_ev      = ev[cfg.run_src];
    assign off_ev      = ev[cfg.off_src];
    assign clr_ev      = ev[cfg.clr_src];
    assign forever_run = cfg.reload || (cfg.rep_cnt == '0);
    assign last_rep    = ({1'b0, reps} + 17'd1) >= {1'b0, cfg.rep_cnt};
    assign pos         = {rcnt, 1'b0};

    // Advance the phase machine and counters on selected events.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase  <= PH_OFFS;
            ocnt   <= '0;
            rcnt   <= '0;
            reps   <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (clr_ev) begin
                phase <= PH_OFFS;
                ocnt  <= '0;
                rcnt  <= '0;
                reps  <= '0;
            end else begin
                case (phase)
                    PH_OFFS: begin
                        if (ocnt == cfg.off_cnt) begin
                            phase <= PH_RUN;
                            rcnt  <= '0;
                        end else if (off_ev) begin
                            ocnt <= ocnt + 1'b1;
                        end
                    end
                    PH_RUN: begin
                        if (run_ev) begin
                            if (rcnt == cfg.run_cnt) begin
                                rcnt   <= '0;
                                strobe <= 1'b1;
                                if (!forever_run && last_rep)
                                    phase <= PH_DONE;
                                else
                                    reps <= reps + 1'b1;
                            end else begin
                                rcnt <= rcnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Edge window on the half-unit position.
    always_comb begin
        wave_raw = (phase == PH_RUN)
                && (pos >= POS_W'(cfg.up))
                && (pos <  POS_W'(cfg.down));
    end
endmodule

// File: rtl/sync_wave_bank.sv
// Bank of chained sync waveform generators with a shared register file.
// Assumes NGEN <= 6; generator strobes are fed back one cycle late as event sources.
module sync_wave_bank
    import swg_pkg::*;
#(
    parameter int NGEN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              pix_tick,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [NGEN-1:0]   wave_o,
    output logic [NGEN-1:0]   strobe_o
);
    gen_cfg_t        cfg_q [NGEN];
    logic [NGEN-1:0] pol_q;
    logic [NGEN-1:0] strobe_q;
    logic [NGEN-1:0] wave_raw;
    logic [NSRC-1:0] ev;

    swg_cfg_regs #(.NGEN(NGEN)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q),
        .pol_q (pol_q)
    );

    // Event vector: none, pixel tick, then each generator's previous strobe.
    assign ev[0] = 1'b0;
    assign ev[1] = pix_tick;
    for (genvar k = SRC_GEN_BASE; k < NSRC; k++) begin : g_ev
        if (k - SRC_GEN_BASE < NGEN) begin : g_live
            assign ev[k] = strobe_q[k-SRC_GEN_BASE];
        end else begin : g_absent
            assign ev[k] = 1'b0;
        end
    end

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        swg_unit u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (run_en),
            .ev       (ev),
            .cfg      (cfg_q[g]),
            .strobe   (strobe_q[g]),
            .wave_raw (wave_raw[g])
        );
    end

    assign strobe_o = strobe_q;
    assign wave_o   = wave_raw ^ pol_q;
endmodule

// File: rtl/sync_wave_bank_chk.sv
// Property checker for the sync waveform bank, attached by bind.
// Assumes it sees the bank's ports plus its polarity word and configuration.
module sync_wave_bank_chk
    import swg_pkg::*;
#(
    parameter int NGEN = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic            pix_tick,
    input logic [NGEN-1:0] wave_o,
    input logic [NGEN-1:0] strobe_o,
    input logic [NGEN-1:0] pol_q,
    input gen_cfg_t        cfg_q [NGEN]
);
    // R11: a disabled bank emits no strobe on the next cycle
    p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (strobe_o == '0));

    // R9: while held, each output equals its polarity bit
    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (wave_o == pol_q));

    // R8: any strobe is caused by a tick or an earlier strobe
    p_strobe_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobe_o) |-> $past(run_en && (pix_tick || (|strobe_o))));

    for (genvar g = 0; g < NGEN; g++) begin : g_chk
        // R10: a generator whose run source was "none" cannot strobe
        p_none_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cfg_q[g].run_src) == '0) |-> !strobe_o[g]);
    end
endmodule

bind sync_wave_bank sync_wave_bank_chk #(.NGEN(NGEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .pix_tick (pix_tick),
    .wave_o   (wave_o),
    .strobe_o (strobe_o),
    .pol_q    (pol_q),
    .cfg_q    (cfg_q)
);

// File: tb/sync_wave_bank_bench.sv
`timescale 1ns/1ps
module sync_wave_bank_bench;
    localparam int NG = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        pix_tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [NG-1:0] wave_o, strobe_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    sync_wave_bank #(.NGEN(NG)) u_sync_wave_bank (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pix_tick(pix_tick),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .wave_o(wave_o), .strobe_o(strobe_o)
    );

    always #4 clk = ~clk;

    // reference model state (state after the most recent edge)
    int m_phase [NG];
    int m_ocnt  [NG];
    int m_rcnt  [NG];
    int m_reps  [NG];
    bit m_strb  [NG];
    int c_run_cnt [NG], c_run_src [NG], c_off_cnt [NG], c_off_src [NG];
    int c_up [NG], c_down [NG], c_clr [NG], c_rep [NG];
    bit c_reload [NG];
    bit m_pol [NG];
    int obs [NG];
    bit compare_on = 0;

    function automatic bit model_wave(int i);
        bit raw;
        raw = (m_phase[i] == 1) && (2*m_rcnt[i] >= c_up[i]) && (2*m_rcnt[i] < c_down[i]);
        return raw ^ m_pol[i];
    endfunction

    function automatic void gen_start(int i);
        m_phase[i] = 0; m_ocnt[i] = 0; m_rcnt[i] = 0; m_reps[i] = 0; m_strb[i] = 0;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < NG; i++) begin
            gen_start(i);
            c_run_cnt[i] = 0; c_run_src[i] = 0; c_off_cnt[i] = 0; c_off_src[i] = 0;
            c_up[i] = 0; c_down[i] = 0; c_clr[i] = 0; c_rep[i] = 0; c_reload[i] = 0;
            m_pol[i] = 0;
        end
    endfunction

    // one clock edge of the reference model
    function automatic void model_next(bit en, bit tick, bit we, logic [4:0] addr, logic [31:0] wd);
        bit ev [8];
        bit ns [NG];
        int g, sel;
        for (int k = 0; k < 8; k++) ev[k] = 0;
        ev[1] = tick;
        for (int k = 2; k < 8; k++) if (k - 2 < NG) ev[k] = m_strb[k-2];
        for (int i = 0; i < NG; i++) begin
            ns[i] = 0;
            if (!en) begin
                gen_start(i);
            end else if (ev[c_clr[i]]) begin
                m_phase[i] = 0; m_ocnt[i] = 0; m_rcnt[i] = 0; m_reps[i] = 0;
            end else if (m_phase[i] == 0) begin
                if (m_ocnt[i] == c_off_cnt[i]) begin m_phase[i] = 1; m_rcnt[i] = 0; end
                else if (ev[c_off_src[i]]) m_ocnt[i] = (m_ocnt[i] + 1) & 12'hFFF;
            end else if (m_phase[i] == 1 && ev[c_run_src[i]]) begin
                if (m_rcnt[i] == c_run_cnt[i]) begin
                    m_rcnt[i] = 0; ns[i] = 1;
                    if (!(c_reload[i] || c_rep[i] == 0) && (m_reps[i] + 1 >= c_rep[i])) m_phase[i] = 2;
                    else m_reps[i] = (m_reps[i] + 1) & 16'hFFFF;
                end else m_rcnt[i] = (m_rcnt[i] + 1) & 12'hFFF;
            end
        end
        for (int i = 0; i < NG; i++) m_strb[i] = ns[i];
        if (we) begin
            g = int'(addr[4:2]); sel = int'(addr[1:0]);
            if (addr == 5'd3) begin
                for (int i = 0; i < NG; i++) m_pol[i] = wd[i];
            end else if (g < NG) begin
                if (sel == 0) begin
                    c_run_cnt[g] = int'(wd[30:19]); c_run_src[g] = int'(wd[18:16]);
                    c_off_cnt[g] = int'(wd[14:3]);  c_off_src[g] = int'(wd[2:0]);
                end else if (sel == 1) begin
                    c_up[g] = int'(wd[9:0]); c_down[g] = int'(wd[25:16]);
                    c_clr[g] = int'(wd[28:26]); c_reload[g] = wd[31];
                end else if (sel == 2) c_rep[g] = int'(wd[15:0]);
            end
        end
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compare, drive, then advance the model for the coming edge
    task automatic cycle(string tag, bit en, bit tick, bit we, logic [4:0] addr, logic [31:0] wd);
        @(negedge clk);
        if (compare_on) begin
            for (int i = 0; i < NG; i++) begin
                check($sformatf("%s strobe gen%0d", tag, i), int'(strobe_o[i]), int'(m_strb[i]));
                check($sformatf("%s wave gen%0d", tag, i), int'(wave_o[i]), int'(model_wave(i)));
                if (strobe_o[i]) obs[i]++;
            end
        end
        run_en = en; pix_tick = tick; cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
        model_next(en, tick, we, addr, wd);
    endtask

    function automatic logic [31:0] w0(int rc, int rs, int oc, int os);
        return (32'(rc) << 19) | (32'(rs) << 16) | (32'(oc) << 3) | 32'(os);
    endfunction
    function automatic logic [31:0] w1(int up, int dn, int clr, bit rl);
        return 32'(up) | (32'(dn) << 16) | (32'(clr) << 26) | (32'(rl) << 31);
    endfunction

    task automatic wr(string tag, int g, int sel, logic [31:0] d);
        cycle(tag, 0, 0, 1, 5'(g*4 + sel), d);
    endtask

    task automatic clear_all(string tag);
        for (int g = 0; g < NG; g++) begin
            wr(tag, g, 0, 0); wr(tag, g, 1, 0); wr(tag, g, 2, 0);
        end
        wr(tag, 0, 3, 0);
    endtask

    task automatic run(string tag, int n, int tick_pct);
        for (int i = 0; i < NG; i++) obs[i] = 0;
        for (int c = 0; c < n; c++)
            cycle(tag, 1, ($urandom % 100) < tick_pct, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 strobe after reset", int'(strobe_o), 0);
        check("R1 wave after reset", int'(wave_o), 0);
        compare_on = 1;

        // R2: pixel period of 4 ticks, count observed strobes
        wr("R12 write", 0, 0, w0(3, 1, 0, 0));
        wr("R12 write", 0, 1, w1(0, 4, 0, 1));
        run("R2 period", 41, 100);
        check("R2 strobe count in 40 ticks", obs[0], 9);

        // R4: three periods then stop
        clear_all("R11 hold");
        wr("R12 write", 0, 0, w0(2, 1, 0, 0));
        wr("R12 write", 0, 1, w1(0, 4, 0, 0));
        wr("R12 write", 0, 2, 3);
        run("R4 repeat", 30, 100);
        check("R4 strobe count with repeat 3", obs[0], 3);

        // R5: reload bit overrides a nonzero repeat; repeat 0 also forever
        wr("R12 write", 0, 1, w1(0, 4, 0, 1));
        wr("R12 write", 1, 0, w0(1, 1, 0, 0));
        run("R5 autoreload", 40, 100);
        check("R5 reload keeps running", int'(obs[0] >= 12), 1);
        check("R5 repeat zero keeps running", int'(obs[1] >= 19), 1);

        // R3: offset on pixel ticks before the first period
        clear_all("R11 hold");
        wr("R12 write", 0, 0, w0(2, 1, 5, 1));
        wr("R12 write", 0, 1, w1(1, 3, 0, 1));
        run("R3 offset", 40, 60);

        // R6: clear coinciding with period end; clear wins
        clear_all("R11 hold");
        wr("R12 write", 0, 0, w0(4, 1, 0, 0));
        wr("R12 write", 1, 0, w0(3, 1, 0, 0));
        wr("R12 write", 1, 1, w1(0, 6, 2, 0));
        run("R6 clear", 41, 100);
        check("R6 gen1 strobes once then loses to clear", obs[1], 1);

        // R7, R8, R9: cascade with edges and inverted outputs
        clear_all("R11 hold");
        wr("R12 write", 0, 0, w0(4, 1, 0, 0));
        wr("R12 write", 0, 1, w1(2, 5, 0, 1));
        wr("R12 write", 1, 0, w0(2, 2, 1, 2));
        wr("R12 write", 1, 1, w1(1, 4, 0, 1));
        wr("R12 write", 2, 0, w0(1, 3, 0, 0));
        wr("R12 write", 2, 1, w1(0, 1, 0, 0));
        wr("R12 write", 0, 3, 32'h5);
        run("R7 R8 R9 cascade", 120, 80);
        check("R8 chained gen2 strobed", int'(obs[2] > 0), 1);

        // R10: none source
        wr("R12 write", 3, 0, w0(0, 0, 0, 0));
        wr("R12 write", 3, 1, w1(0, 4, 0, 1));
        run("R10 none source", 30, 100);
        check("R10 no strobes from none source", obs[3], 0);

        // R11: disabled bank is quiet
        for (int c = 0; c < 5; c++) cycle("R11 hold", 0, 1, 0, 0, 0);
        check("R11 strobes while held", int'(strobe_o), 0);

        // random configurations
        for (int s = 0; s < 40; s++) begin
            for (int g = 0; g < NG; g++) begin
                wr("R12 write", g, 0, w0($urandom % 6, $urandom % 8, $urandom % 4, $urandom % 8));
                wr("R12 write", g, 1, w1($urandom % 13, $urandom % 15,
                                         ($urandom % 2) ? 0 : ($urandom % 8), 1'($urandom % 2)));
                wr("R12 write", g, 2, $urandom % 5);
            end
            wr("R9 write", 0, 3, $urandom);
            run("R8 random", 200, 70);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule